// File: doc/BRIEF.md
# Adaptive Reference Trajectory Generator

This block generates the reference path that a divided-down phase error must follow during a timed phase-lock interval. A start pulse captures the measured phase error at that moment as the starting point, so the loop sees no step at the start. The block then walks through a 1024-sample gain curve that falls from unity to zero and scales the captured error and a selectable final offset by that gain. The output moves smoothly from the captured error to the negated offset.

The gain sample is a weighted mix, computed each cycle, of two fixed curves held in on-chip tables. The weight is a live input. The number of clock cycles spent on each sample is worked out once, at the start pulse. It is a base count plus a fixed extra term that applies only when the lock trigger was found in the early test. A signed correction proportional to how far the triggering zero-crossing count lay past the threshold is also added. Three parameter sets cover the no-correction case and the plus-one-bucket and minus-one-bucket correction cases. A mode input picks one of them at the start pulse.

Top module: `traj_gen`

## Requirements
- R1: After reset, `traj` is 0 and `active` is 0.
- R2: In the cycle after a clock edge where `start` is high, `traj` equals the `phase_err` value sampled at that edge and `active` is 1.
- R3: Sample n (0..1023) uses gain g(n) = floor((alpha*U(n) + (4096-alpha)*L(n))/4096), where U(n) = floor(4096*(1023-n)/1023) and L(n) = floor(4096*(1023-n)^2/1023^2). 4096 stands for unity. `alpha` is applied live rather than latched.
- R4: The output is floor((e+o)*g/4096) - o. Here e is the latched error and o is the selected offset register minus 0x8000, since the register is 16-bit offset binary.
- R5: The result is saturated to the signed 14-bit range [-8192, 8191].
- R6: Sample n appears on `traj` from cycle n*I to cycle (n+1)*I-1, counting from the first cycle after the start edge. The base of I is bits [15:8] of the selected interval register. Bits [7:0] of that register are added to I only when `alt_slope` is 1 at the start edge.
- R7: I also gains floor((slope_gain-0x2000)*(trig_count-trig_thresh)/8192), where `slope_gain` is 14-bit offset binary. The total is clamped to [1, 65535].
- R8: `mode` selects the parameter set: 0 for none, 1 for plus, 2 for minus, and 3 acts as 0. `mode`, `phase_err`, `trig_count`, `trig_thresh`, `alt_slope`, `slope_gain` and the interval and offset registers take effect only at a start edge. Changing them at any other time has no effect on `traj`.
- R9: Once sample 1023 is reached, `active` falls and `traj` holds saturate(-o) until the next start.
- R10: A start while the block is running restarts it from sample 0 with newly latched values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a trajectory; latches error and parameters |
| mode | input | 2 | Parameter set select |
| phase_err | input | 14 | Measured divided phase error, signed |
| trig_count | input | 16 | Zero-crossing count at the trigger |
| trig_thresh | input | 16 | Zero-crossing count threshold |
| alt_slope | input | 1 | Trigger was seen in the early test |
| alpha | input | 12 | Upper-curve weight, alpha/4096 |
| slope_gain | input | 14 | Interval correction gain, offset binary |
| ivl_none | input | 16 | Base/extra interval bytes, no correction |
| ivl_plus | input | 16 | Base/extra interval bytes, plus correction |
| ivl_minus | input | 16 | Base/extra interval bytes, minus correction |
| off_none | input | 16 | Final offset, no correction |
| off_plus | input | 16 | Final offset, plus correction |
| off_minus | input | 16 | Final offset, minus correction |
| traj | output | 14 | Reference trajectory sample, signed |
| active | output | 1 | Trajectory is still stepping |

## Verification
The bench compares every cycle of each trajectory against a model that covers the first-cycle value, the dwell time of each sample and the final hold. A design that registered the output one stage late, or counted the dwell off by one, would be off by one sample at each step boundary. Directed runs push the interval correction to a negative total, which must clamp to 1, and use the largest positive gain, which checks that the floor rounding is right. A near-full-scale offset checks that saturation is applied rather than letting the value wrap. During each run the bench changes the latched-only inputs, and it also issues a restart partway through a run. A design that read those inputs live, or that failed to clear its step counter on restart, would drift from the model.

// File: rtl/traj_gen.sv
module traj_gen #(
  parameter int CURVE_LEN = 1024,
  parameter int SW = 14,
  parameter int AW = 12,
  parameter int CW = 16,
  parameter int GW = 14,
  parameter int PW = 16,
  parameter int BW = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  input  logic [1:0]           mode,
  input  logic signed [SW-1:0] phase_err,
  input  logic [CW-1:0]        trig_count,
  input  logic [CW-1:0]        trig_thresh,
  input  logic                 alt_slope,
  input  logic [AW-1:0]        alpha,
  input  logic [GW-1:0]        slope_gain,
  input  logic [2*BW-1:0]      ivl_none,
  input  logic [2*BW-1:0]      ivl_plus,
  input  logic [2*BW-1:0]      ivl_minus,
  input  logic [PW-1:0]        off_none,
  input  logic [PW-1:0]        off_plus,
  input  logic [PW-1:0]        off_minus,
  output logic signed [SW-1:0] traj,
  output logic                 active
);
  localparam int IW    = $clog2(CURVE_LEN);
  localparam int LAST  = CURVE_LEN - 1;
  localparam int UNITY = 2 ** AW;
  localparam int GZERO = 2 ** (GW - 1);
  localparam int PZERO = 2 ** (PW - 1);
  localparam int MAXI  = 2 ** CW - 1;
  localparam int SUMW  = GW + CW + 2;
  localparam int BLW   = SW + AW + 2;
  localparam int RW    = SW + PW + SW + 2;
  localparam int SMAX  = 2 ** (SW - 1) - 1;
  localparam int SMIN  = -(2 ** (SW - 1));

  function automatic logic signed [SW-1:0] up_val(int n);
    longint r;
    r = longint'(LAST - n);
    return SW'(longint'(UNITY) * r / longint'(LAST));
  endfunction

  function automatic logic signed [SW-1:0] lo_val(int n);
    longint r;
    r = longint'(LAST - n);
    return SW'(longint'(UNITY) * r * r / (longint'(LAST) * longint'(LAST)));
  endfunction

  logic signed [SW-1:0] rom_up [CURVE_LEN];
  logic signed [SW-1:0] rom_lo [CURVE_LEN];

  for (genvar n = 0; n < CURVE_LEN; n++) begin : g_rom
    assign rom_up[n] = up_val(n);
    assign rom_lo[n] = lo_val(n);
  end

  logic [IW-1:0]        idx;
  logic [CW-1:0]        cnt, ivl_q;
  logic signed [SW-1:0] err_q;
  logic signed [PW:0]   off_q;
  logic                 done;

  logic [2*BW-1:0] ivl_sel;
  logic [PW-1:0]   off_sel;

  always_comb begin
    case (mode)
      2'd1:    begin ivl_sel = ivl_plus;  off_sel = off_plus;  end
      2'd2:    begin ivl_sel = ivl_minus; off_sel = off_minus; end
      default: begin ivl_sel = ivl_none;  off_sel = off_none;  end
    endcase
  end

  logic signed [GW:0]     sg;
  logic signed [CW:0]     diff;
  logic signed [SUMW-1:0] prod, adj, isum;
  logic [CW-1:0]          ivl_c;
  logic signed [PW:0]     off_c;

  assign sg   = $signed({1'b0, slope_gain}) - $signed((GW+1)'(GZERO));
  assign diff = $signed({1'b0, trig_count}) - $signed({1'b0, trig_thresh});
  assign prod = SUMW'(sg) * SUMW'(diff);
  assign adj  = prod >>> (GW - 1);
  assign isum = adj + $signed(SUMW'(ivl_sel[2*BW-1:BW]))
              + (alt_slope ? $signed(SUMW'(ivl_sel[BW-1:0])) : SUMW'(0));
  assign ivl_c = (isum < SUMW'(1)) ? CW'(1) :
                 (isum > SUMW'(MAXI)) ? CW'(MAXI) : isum[CW-1:0];
  assign off_c = $signed({1'b0, off_sel}) - $signed((PW+1)'(PZERO));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx   <= '0;
      cnt   <= '0;
      ivl_q <= CW'(1);
      err_q <= '0;
      off_q <= '0;
      done  <= 1'b1;
    end else if (start) begin
      idx   <= '0;
      cnt   <= '0;
      ivl_q <= ivl_c;
      err_q <= phase_err;
      off_q <= off_c;
      done  <= 1'b0;
    end else if (!done) begin
      if (cnt == ivl_q - 1'b1) begin
        cnt <= '0;
        idx <= idx + 1'b1;
        if (idx == IW'(LAST - 1)) done <= 1'b1;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  logic signed [SW-1:0]  up_s, lo_s, g;
  logic signed [BLW-1:0] wa, wb, blend;

  assign up_s  = rom_up[idx];
  assign lo_s  = rom_lo[idx];
  assign wa    = $signed(BLW'(alpha));
  assign wb    = BLW'(UNITY) - wa;
  assign blend = BLW'(up_s) * wa + BLW'(lo_s) * wb;
  assign g     = done ? '0 : SW'(blend >>> AW);

  logic signed [RW-1:0] acc, scaled;

  assign acc    = (RW'(err_q) + RW'(off_q)) * RW'(g);
  assign scaled = (acc >>> AW) - RW'(off_q);

  always_comb begin
    if (scaled > RW'(SMAX))      traj = SW'(SMAX);
    else if (scaled < RW'(SMIN)) traj = SW'(SMIN);
    else                         traj = scaled[SW-1:0];
  end

  assign active = !done;

  a_r2_start_latch: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (traj == $past(phase_err) && active));

  a_r2_active_rise: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(active) |-> $past(start));

  a_r6_dwell_bound: assert property (@(posedge clk) disable iff (!rst_n)
    active |-> (cnt < ivl_q));

  a_r6_single_step: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !start) |=> (idx == $past(idx) || idx == $past(idx) + 1'b1));

  a_r7_interval_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (ivl_q != '0));

  a_r9_end_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!active && !start) |=> ($stable(traj) && !active));
endmodule

// File: tb/traj_gen_test.sv
module traj_gen_test;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n, start, alt_slope;
  logic [1:0] mode;
  logic signed [13:0] phase_err, traj;
  logic [15:0] trig_count, trig_thresh;
  logic [11:0] alpha;
  logic [13:0] slope_gain;
  logic [15:0] ivl_none, ivl_plus, ivl_minus, off_none, off_plus, off_minus;
  logic active;

  traj_gen uut (
    .clk(clk), .rst_n(rst_n), .start(start), .mode(mode), .phase_err(phase_err),
    .trig_count(trig_count), .trig_thresh(trig_thresh), .alt_slope(alt_slope),
    .alpha(alpha), .slope_gain(slope_gain), .ivl_none(ivl_none), .ivl_plus(ivl_plus),
    .ivl_minus(ivl_minus), .off_none(off_none), .off_plus(off_plus),
    .off_minus(off_minus), .traj(traj), .active(active)
  );

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  task automatic chk(input bit ok, input string req, input string tag,
                     input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s [%s]: got %0d expected %0d", req, tag, act, exp);
    end
  endtask

  function automatic longint sat14(longint v);
    if (v > 8191) return 8191;
    if (v < -8192) return -8192;
    return v;
  endfunction

  function automatic longint exp_traj(longint e, longint o, longint a, int n);
    longint u, l, g, r;
    if (n >= 1023) g = 0;
    else begin
      u = (64'sd4096 * (1023 - n)) / 1023;
      l = (64'sd4096 * (1023 - n) * (1023 - n)) / (64'sd1023 * 1023);
      g = (a * u + (4096 - a) * l) >>> 12;
    end
    r = (((e + o) * g) >>> 12) - o;
    return sat14(r);
  endfunction

  function automatic longint exp_ivl(longint base, longint extra, bit alt,
                                     longint gain, longint cnt, longint thr);
    longint s;
    s = base + (alt ? extra : 0) + (((gain - 8192) * (cnt - thr)) >>> 13);
    if (s < 1) s = 1;
    if (s > 65535) s = 65535;
    return s;
  endfunction

  task automatic scramble;
    phase_err   = 14'($urandom);
    mode        = 2'($urandom);
    trig_count  = 16'($urandom);
    trig_thresh = 16'($urandom);
    alt_slope   = 1'($urandom);
    slope_gain  = 14'($urandom);
    ivl_none    = 16'($urandom);
    ivl_plus    = 16'($urandom);
    ivl_minus   = 16'($urandom);
    off_none    = 16'($urandom);
    off_plus    = 16'($urandom);
    off_minus   = 16'($urandom);
  endtask

  task automatic run(input logic [1:0] md, input longint e, input logic [11:0] a,
                     input bit alt, input longint cnt, input longint thr, input longint gain,
                     input logic [15:0] ivn, input logic [15:0] ivp, input logic [15:0] ivm,
                     input logic [15:0] ofn, input logic [15:0] ofp, input logic [15:0] ofm,
                     input int stop_at, input string tag);
    logic [15:0] iv, of;
    longint ivl, o;
    int lim;
    iv = (md == 2'd1) ? ivp : (md == 2'd2) ? ivm : ivn;
    of = (md == 2'd1) ? ofp : (md == 2'd2) ? ofm : ofn;
    ivl = exp_ivl(longint'(iv[15:8]), longint'(iv[7:0]), alt, gain, cnt, thr);
    o = longint'(of) - 32768;
    mode = md; phase_err = 14'(e); alpha = a; alt_slope = alt;
    trig_count = 16'(cnt); trig_thresh = 16'(thr); slope_gain = 14'(gain);
    ivl_none = ivn; ivl_plus = ivp; ivl_minus = ivm;
    off_none = ofn; off_plus = ofp; off_minus = ofm;
    start = 1'b1;
    lim = (stop_at > 0) ? stop_at : int'(1023 * ivl) + 6;
    for (int k = 0; k < lim; k++) begin
      @(negedge clk);
      start = 1'b0;
      if (k > 0) scramble();
      begin
        int n;
        longint ex;
        n = int'(longint'(k) / ivl);
        if (n > 1023) n = 1023;
        ex = exp_traj(e, o, longint'(a), n);
        if (k == 0)
          chk(traj == 14'(ex), "R2 start value", tag, longint'(traj), ex);
        else if (n == 1023)
          chk(traj == 14'(ex), "R9 end hold", tag, longint'(traj), ex);
        else
          chk(traj == 14'(ex), "R4 trajectory", tag, longint'(traj), ex);
        chk(active == (n < 1023), "R6 step timing", tag, longint'(active),
            longint'(n < 1023));
      end
    end
  endtask

  initial begin
    #2000000;
    if (!finished) begin
      bad++;
      total++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    rst_n = 1'b0; start = 1'b0; alpha = 12'd2048;
    scramble();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(traj == 14'sd0, "R1 reset traj", "reset", longint'(traj), 0);
    chk(active == 1'b0, "R1 reset active", "reset", longint'(active), 0);

    run(2'd0, 1000, 12'd2048, 1'b0, 100, 100, 8192,
        16'h0100, 16'h0500, 16'h0500, 16'h8000 + 16'd300, 16'h8000, 16'h8000, 0, "R3 unit step");
    run(2'd0, -500, 12'd1000, 1'b0, 150, 100, 0,
        16'h0100, 16'h0100, 16'h0100, 16'h8000, 16'h8000, 16'h8000, 0, "R7 clamp to one");
    run(2'd1, 2000, 12'd4095, 1'b1, 108, 100, 16383,
        16'h0200, 16'h0302, 16'h0100, 16'h8000, 16'h7F00, 16'h8000, 0, "R6 alt extra R7 gain");
    run(2'd2, -3000, 12'd0, 1'b0, 100, 100, 8192,
        16'h0100, 16'h0100, 16'h0203, 16'h8000, 16'h8000, 16'h8400, 0, "R8 minus set");
    run(2'd3, 8000, 12'd3000, 1'b0, 100, 100, 8192,
        16'h0100, 16'h0400, 16'h0400, 16'hFFFF, 16'h0000, 16'h8000, 0, "R5 saturate mode3");
    run(2'd1, 1500, 12'd1500, 1'b0, 100, 100, 8192,
        16'h0300, 16'h0300, 16'h0300, 16'h8000, 16'h8100, 16'h8000, 300, "R10 first run");
    run(2'd2, -1200, 12'd1500, 1'b1, 90, 100, 9000,
        16'h0100, 16'h0100, 16'h0201, 16'h8000, 16'h8000, 16'h7E00, 0, "R10 restart");

    for (int r = 0; r < 4; r++) begin
      run(2'($urandom), longint'($urandom_range(0, 12000)) - 6000,
          12'($urandom), 1'($urandom),
          longint'($urandom_range(60, 140)), 100,
          longint'($urandom_range(8092, 8292)),
          {8'($urandom_range(1, 6)), 8'($urandom_range(0, 4))},
          {8'($urandom_range(1, 6)), 8'($urandom_range(0, 4))},
          {8'($urandom_range(1, 6)), 8'($urandom_range(0, 4))},
          16'($urandom_range(28000, 37000)), 16'($urandom_range(28000, 37000)),
          16'($urandom_range(28000, 37000)), 0, "R8 random");
    end

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule